// File: doc/BRIEF.md
# Five-Channel Timer Tick Generator

This block derives a tick-enable pulse for each of five timer channels from a single peripheral clock. Two programmable 8-bit prescalers divide the peripheral clock. The channels split unevenly between them: channels 0 and 1 hang off the first prescaler, and channels 2, 3 and 4 hang off the second. Each channel then applies its own power-of-two divide. Its 4-bit selector can instead switch the channel over to one of two external timer clock inputs. Every output is a single-cycle clock enable in the peripheral clock domain, so the timer counters downstream use it as an enable and never as a clock.

Software programs the block through two 32-bit registers on a simple synchronous register bus. The register at offset 0x0 holds both prescaler values. The register at offset 0x4 packs the five channel selectors. Because the divide ratio and the external-clock switch share one selector field, a channel's source and ratio always change together. Any write restarts the counters it affects, so each new setting starts a whole period. A module parameter picks one of two selector encodings.

Top module: `tmr_tick_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every `tick_en` bit is 0. After reset, reads of offsets 0x0 and 0x4 return zero.
- R2: A write to offset 0x0 stores bits 15:0 and a write to offset 0x4 stores bits 19:0. Register bits above those read as zero. A read returns the stored value on `cfg_rdata` one cycle after the address is presented. Writes to any other offset change nothing, and reads of any other offset return zero.
- R3: Prescaler k takes its value N from bits 8k+7:8k of offset 0x0 and emits one pulse every N+1 peripheral clock cycles.
- R4: Channels 0 and 1 are driven from prescaler 0 and external input 0. Channels 2, 3 and 4 are driven from prescaler 1 and external input 1.
- R5: With the direct selector map (the default), the selector of channel c sits in bits 4c+3:4c of offset 0x4. Values 0, 1, 2, 3 and 4 divide the prescaler pulses by 1, 2, 4, 8 and 16.
- R6: With the shifted selector map, selector values 0, 1, 2 and 3 divide the prescaler pulses by 2, 4, 8 and 16.
- R7: The direct map selects the external input for any selector value of 5 or above. The shifted map selects it for any value of 4 or above. A channel on an external source ignores its prescaler and ignores the other external input.
- R8: A channel on an external source gives exactly one single-cycle tick per rising edge of its input. The tick appears at the third rising clock edge after the input rises.
- R9: A write to offset 0x0 restarts both prescalers and all channel dividers. For prescaler value N and divide D, the first tick comes N+3+(D-1)(N+1) clock edges after the write edge.
- R10: In divided mode, a tick is one cycle wide whenever the channel period exceeds one cycle, and each tick follows a prescaler pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Byte offset of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| ext_clk_in | input | 2 | External timer clocks, asynchronous |
| tick_en | output | 5 | Per-channel single-cycle tick enables |

## Verification
The properties assume that external clock levels are free of glitches once they have passed the two synchronizing flops. They also assume that each external level lasts longer than a clock cycle, so that one rising input edge maps to one pulse. The stimulus holds every external level for four peripheral cycles. It uses only the two defined offsets, apart from one deliberate access to an unused offset. The divided-mode checks run only on settings where the channel period is longer than one cycle, so single-cycle ticks can be told apart.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  localparam int SEL_W   = 4;
  localparam int SHIFT_W = 3;
  localparam int MAX_SHIFT = 4;

  typedef enum logic {
    SEL_MAP_SHIFTED = 1'b0,
    SEL_MAP_DIRECT  = 1'b1
  } sel_map_e;

  typedef struct packed {
    logic               use_ext;
    logic [SHIFT_W-1:0] shift;
  } src_cfg_t;

  function automatic src_cfg_t decode_sel(input logic [SEL_W-1:0] code,
                                          input sel_map_e map);
    src_cfg_t r;
    r.use_ext = 1'b0;
    r.shift   = '0;
    if (map == SEL_MAP_SHIFTED) begin
      if (code < SEL_W'(MAX_SHIFT)) r.shift = SHIFT_W'(code) + SHIFT_W'(1);
      else                          r.use_ext = 1'b1;
    end else begin
      if (code <= SEL_W'(MAX_SHIFT)) r.shift = SHIFT_W'(code);
      else                           r.use_ext = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tmr_cfg_regs.sv
`timescale 1ns/1ps
module tmr_cfg_regs #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_PRE = 2,
  parameter int PRE_W   = 8,
  parameter int NUM_CH  = 5
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [DATA_W-1:0]                      wdata,
  output logic [DATA_W-1:0]                      rdata,
  output logic [NUM_PRE-1:0][PRE_W-1:0]          pre_val,
  output logic [NUM_CH-1:0][tmr_pkg::SEL_W-1:0]  sel_val,
  output logic [NUM_PRE-1:0]                     pre_restart,
  output logic [NUM_CH-1:0]                      ch_restart
);
  localparam int PRE_BITS = NUM_PRE * PRE_W;
  localparam int SEL_BITS = NUM_CH * tmr_pkg::SEL_W;
  localparam int OFF_PRE  = 0;
  localparam int OFF_SEL  = 4;

  logic [PRE_BITS-1:0] pre_reg;
  logic [SEL_BITS-1:0] sel_reg;
  logic hit_pre, hit_sel;

  wire unused_wdata = ^wdata[DATA_W-1:SEL_BITS];

  assign hit_pre = wr_en && (addr == ADDR_W'(OFF_PRE));
  assign hit_sel = wr_en && (addr == ADDR_W'(OFF_SEL));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_reg     <= '0;
      sel_reg     <= '0;
      pre_restart <= '0;
      ch_restart  <= '0;
      rdata       <= '0;
    end else begin
      if (hit_pre) pre_reg <= wdata[PRE_BITS-1:0];
      if (hit_sel) sel_reg <= wdata[SEL_BITS-1:0];
      pre_restart <= {NUM_PRE{hit_pre}};
      ch_restart  <= {NUM_CH{hit_sel}};
      if (addr == ADDR_W'(OFF_PRE))      rdata <= DATA_W'(pre_reg);
      else if (addr == ADDR_W'(OFF_SEL)) rdata <= DATA_W'(sel_reg);
      else                               rdata <= '0;
    end
  end

  for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre_unpack
    assign pre_val[p] = pre_reg[p*PRE_W +: PRE_W];
  end
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel_unpack
    assign sel_val[c] = sel_reg[c*tmr_pkg::SEL_W +: tmr_pkg::SEL_W];
  end

  AST_WR_RESTART: assert property (@(posedge clk) disable iff (rst)
    hit_pre |=> (&pre_restart)); // R9

endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PRE_W-1:0] div_val,
  output logic             pulse
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == div_val) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + PRE_W'(1);
      pulse <= 1'b0;
    end
  end

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (rst)
    (pulse && div_val != '0 && !restart) |=> !pulse); // R3

endmodule

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R8

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan #(
  parameter tmr_pkg::sel_map_e MAP = tmr_pkg::SEL_MAP_DIRECT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      restart,
  input  logic [tmr_pkg::SEL_W-1:0] sel,
  input  logic                      pre_pulse,
  input  logic                      ext_rise,
  output logic                      tick
);
  localparam int DC_W = tmr_pkg::MAX_SHIFT;

  tmr_pkg::src_cfg_t src;
  logic [DC_W-1:0]   dc;
  logic [DC_W-1:0]   lim;
  logic              tick_ext;

  assign src = tmr_pkg::decode_sel(sel, MAP);
  assign lim = DC_W'((1 << src.shift) - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      dc       <= '0;
      tick     <= 1'b0;
      tick_ext <= 1'b0;
    end else begin
      tick_ext <= src.use_ext;
      if (src.use_ext) begin
        tick <= ext_rise;
      end else begin
        tick <= 1'b0;
        if (pre_pulse) begin
          if (dc == lim) begin
            dc   <= '0;
            tick <= 1'b1;
          end else begin
            dc <= dc + DC_W'(1);
          end
        end
      end
    end
  end

  AST_DIV_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (tick && !tick_ext) |-> $past(pre_pulse)); // R10

  AST_DIV_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (tick && !tick_ext && lim != '0 && !restart) |=> !tick); // R10

  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (tick && tick_ext) |=> !tick); // R8

endmodule

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int PRE_W   = 8,
  parameter int NUM_CH  = 5,
  parameter int GRP0_CH = 2,
  parameter tmr_pkg::sel_map_e VARIANT = tmr_pkg::SEL_MAP_DIRECT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [1:0]        ext_clk_in,
  output logic [NUM_CH-1:0] tick_en
);
  localparam int NUM_GRP = 2;

  logic [NUM_GRP-1:0][PRE_W-1:0]         pre_val;
  logic [NUM_CH-1:0][tmr_pkg::SEL_W-1:0] sel_val;
  logic [NUM_GRP-1:0]                    pre_rst;
  logic [NUM_CH-1:0]                     ch_rst;
  logic [NUM_GRP-1:0]                    pre_pulse;
  logic [NUM_GRP-1:0]                    ext_rise;

  tmr_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PRE(NUM_GRP),
    .PRE_W(PRE_W), .NUM_CH(NUM_CH)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .pre_val(pre_val),
    .sel_val(sel_val), .pre_restart(pre_rst), .ch_restart(ch_rst)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst(rst), .restart(pre_rst[g]),
      .div_val(pre_val[g]), .pulse(pre_pulse[g])
    );
    tmr_edge_sync u_sync (
      .clk(clk), .rst(rst), .async_in(ext_clk_in[g]), .rise(ext_rise[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = (c < GRP0_CH) ? 0 : 1;
    tmr_chan #(.MAP(VARIANT)) u_chan (
      .clk(clk), .rst(rst), .restart(ch_rst[c] | pre_rst[GRP]),
      .sel(sel_val[c]), .pre_pulse(pre_pulse[GRP]),
      .ext_rise(ext_rise[GRP]), .tick(tick_en[c])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (tick_en == '0)); // R1

endmodule

// File: tb/tmr_tick_gen_bench.sv
`timescale 1ns/1ps
module tmr_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  ext = '0;
  logic [31:0] rdata_b, rdata_a;
  logic [4:0]  tick_b, tick_a;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cnt_b[5];
  int cnt_a[5];

  always #2.5 clk = ~clk;

  tmr_tick_gen u_tmr_tick_gen (
    .clk(clk), .rst(rst), .cfg_we(wr), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_rdata(rdata_b), .ext_clk_in(ext), .tick_en(tick_b)
  );

  tmr_tick_gen #(.VARIANT(tmr_pkg::SEL_MAP_SHIFTED)) u_tmr_tick_gen_va (
    .clk(clk), .rst(rst), .cfg_we(wr), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_rdata(rdata_a), .ext_clk_in(ext), .tick_en(tick_a)
  );

  always @(negedge clk) begin
    for (int c = 0; c < 5; c++) begin
      if (tick_b[c]) cnt_b[c]++;
      if (tick_a[c]) cnt_a[c]++;
    end
  end

  function automatic logic tk(input int inst, input int ch);
    return (inst == 0) ? tick_b[ch] : tick_a[ch];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(posedge clk); #1;
    for (int c = 0; c < 5; c++) begin cnt_b[c] = 0; cnt_a[c] = 0; end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] vb, output logic [31:0] va);
    @(negedge clk); addr = a;
    @(negedge clk); vb = rdata_b; va = rdata_a;
  endtask

  task automatic measure(input int inst, input int ch, output int period, output bit width_ok);
    int n;
    period = -1; width_ok = 1'b1; n = 0;
    @(negedge clk);
    while (!tk(inst, ch) && n < 600) begin @(negedge clk); n++; end
    if (!tk(inst, ch)) return;
    @(negedge clk); n = 1;
    if (tk(inst, ch)) width_ok = 1'b0;
    while (!tk(inst, ch) && n < 600) begin @(negedge clk); n++; end
    if (tk(inst, ch)) period = n;
  endtask

  task automatic ext_pulses(input int idx, input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk); ext[idx] = 1'b1;
      repeat (4) @(negedge clk);
      ext[idx] = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] vb, va;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(tick_b == 5'd0 && tick_a == 5'd0, "R1 ticks during reset", int'({tick_a, tick_b}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tick_b == 5'd0 && tick_a == 5'd0, "R1 ticks after reset", int'({tick_a, tick_b}), 0);
    bus_read(4'h0, vb, va);
    chk(vb == 0 && va == 0, "R1 reg0 reset", int'(vb | va), 0);
    bus_read(4'h4, vb, va);
    chk(vb == 0 && va == 0, "R1 reg1 reset", int'(vb | va), 0);
  endtask

  task automatic t_regs();
    logic [31:0] vb, va;
    bus_write(4'h0, 32'hFFFF_ABCD);
    bus_read(4'h0, vb, va);
    chk(vb == 32'h0000_ABCD && va == vb, "R2 reg0 readback", int'(vb), 32'hABCD);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, vb, va);
    chk(vb == 32'h000F_FFFF && va == vb, "R2 reg1 readback", int'(vb), 32'hFFFFF);
    bus_write(4'h8, 32'h1234_5678);
    bus_read(4'h8, vb, va);
    chk(vb == 0, "R2 unused offset read", int'(vb), 0);
    bus_read(4'h0, vb, va);
    chk(vb == 32'h0000_ABCD, "R2 unused offset write ignored", int'(vb), 32'hABCD);
  endtask

  task automatic t_prescale();
    int exp_b[5] = '{3, 3, 5, 5, 5};
    int exp_a[5] = '{6, 6, 10, 10, 10};
    int p;
    bit w;
    bus_write(4'h0, 32'h0000_0402);
    bus_write(4'h4, 32'h0000_0000);
    for (int c = 0; c < 5; c++) begin
      measure(0, c, p, w);
      chk(p == exp_b[c] && w, "R3 R4 direct-map prescale period", p, exp_b[c]);
      measure(1, c, p, w);
      chk(p == exp_a[c] && w, "R4 R6 shifted-map prescale period", p, exp_a[c]);
    end
  endtask

  task automatic t_divide();
    int exp_b[5] = '{3, 6, 20, 40, 80};
    int exp_a[4] = '{6, 12, 40, 80};
    int p;
    bit w;
    bus_write(4'h4, 32'h0004_3210);
    for (int c = 0; c < 5; c++) begin
      measure(0, c, p, w);
      chk(p == exp_b[c], "R5 direct-map divide period", p, exp_b[c]);
      chk(w, "R10 divided tick width", 2, 1);
    end
    for (int c = 0; c < 4; c++) begin
      measure(1, c, p, w);
      chk(p == exp_a[c] && w, "R6 shifted-map divide period", p, exp_a[c]);
    end
    clear_counts();
    repeat (200) @(negedge clk);
    chk(cnt_a[4] == 0, "R7 shifted-map code 4 idle external", cnt_a[4], 0);
  endtask

  task automatic t_extsel();
    bus_write(4'h4, 32'h0000_4F15);
    clear_counts();
    ext_pulses(0, 3);
    chk(cnt_b[0] == 3, "R7 direct ch0 code 5 on ext0", cnt_b[0], 3);
    chk(cnt_b[2] == 0, "R7 direct ch2 ignores ext0", cnt_b[2], 0);
    chk(cnt_a[0] == 3, "R7 shifted ch0 on ext0", cnt_a[0], 3);
    chk(cnt_a[2] == 0 && cnt_a[3] == 0, "R4 shifted ch2/ch3 ignore ext0", cnt_a[2] + cnt_a[3], 0);
    clear_counts();
    ext_pulses(1, 4);
    chk(cnt_b[0] == 0, "R4 direct ch0 ignores ext1", cnt_b[0], 0);
    chk(cnt_b[2] == 4, "R7 direct ch2 code 15 on ext1", cnt_b[2], 4);
    chk(cnt_a[2] == 4, "R7 shifted ch2 on ext1", cnt_a[2], 4);
    chk(cnt_a[3] == 4, "R7 shifted ch3 code 4 on ext1", cnt_a[3], 4);
    chk(cnt_a[0] == 0, "R4 shifted ch0 ignores ext1", cnt_a[0], 0);
  endtask

  task automatic t_ext_latency();
    int k, ka;
    bus_write(4'h4, 32'h0000_0005);
    repeat (6) @(negedge clk);
    @(negedge clk); ext[0] = 1'b1;
    k = 0; ka = 0;
    while (k < 10 && !tick_b[0]) begin
      @(posedge clk); #1; k++;
      if (tick_a[0] && ka == 0) ka = k;
    end
    chk(k == 3, "R8 direct external tick latency", k, 3);
    chk(ka == 3, "R8 shifted external tick latency", ka, 3);
    @(posedge clk); #1;
    chk(!tick_b[0] && !tick_a[0], "R8 external tick one cycle", int'(tick_b[0]), 0);
    @(negedge clk); ext[0] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_restart();
    int k, kb, ka;
    bus_write(4'h0, 32'h0000_0003);
    bus_write(4'h4, 32'h0000_0001);
    repeat (50) @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = 4'h0; wdata = 32'h0000_0003;
    @(posedge clk); #1; wr = 1'b0;
    kb = 0; ka = 0;
    for (k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      if (tick_b[0] && kb == 0) kb = k;
      if (tick_a[0] && ka == 0) ka = k;
    end
    chk(kb == 10, "R9 direct first tick after rewrite", kb, 10);
    chk(ka == 18, "R9 shifted first tick after rewrite", ka, 18);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 5; c++) begin cnt_b[c] = 0; cnt_a[c] = 0; end
    t_reset();
    t_regs();
    t_prescale();
    t_divide();
    t_extsel();
    t_ext_latency();
    t_restart();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule